// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens a raster image along the slow (line-to-line) scan direction. Each cycle it can accept three vertically aligned 8-bit pixels. `pix_below` is the live pixel of line n+1. `pix_centre` is the same column of line n, taken from a one-line delay. `pix_above` is line n-1, taken from a two-line delay.

From these it forms an edge term: twice the centre minus the sum of the two neighbours. It scales that term by a programmable gain and adds the result back to the centre pixel. The corrected pixel is saturated to the 8-bit range before it leaves the block.

The datapath is a three-stage pipeline with a valid flag that runs alongside the data. A stage loads new contents only when the data entering it is valid. A gap in the input stream therefore freezes the output pixel rather than corrupting it. The line delays that feed the block sit outside it.

Top module: `vlap_sharpen`

## Requirements
- R1: While `rst_n` is low and after its release, before any valid input has travelled through, `out_valid` is 0 and `out_pix` is 0.
- R2: The edge term is E = 2·`pix_centre` − (`pix_above` + `pix_below`), exact and signed. When all three pixels are equal, E = 0 and the output equals `pix_centre` for every gain.
- R3: `gain` is an unsigned fixed-point number with 4 integer and 4 fraction bits (value = `gain`/16). It is captured together with the pixels it applies to. The scaled term is floor((E·`gain` + 8) / 16), which rounds to nearest with ties toward plus infinity.
- R4: Before saturation, the result is `pix_centre` plus the scaled term, computed without overflow for all inputs.
- R5: A result below 0 is output as 0, and a result above 255 is output as 255.
- R6: A pixel set sampled with `in_valid` high on a rising edge produces `out_valid` high, with its result on `out_pix`, after exactly the third rising edge. Back-to-back valid inputs produce back-to-back results.
- R7: Cycles with `in_valid` low advance no data. While `out_valid` is low, `out_pix` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The three pixels and gain are valid this cycle |
| pix_above | input | 8 | Pixel of line n-1 (two-line delay) |
| pix_centre | input | 8 | Pixel of line n (one-line delay) |
| pix_below | input | 8 | Pixel of line n+1 (live input) |
| gain | input | 8 | Edge gain, unsigned, 4 integer and 4 fraction bits |
| out_valid | output | 1 | `out_pix` carries a new result |
| out_pix | output | 8 | Sharpened, saturated pixel |

## Verification
The bench targets the extremes of the edge term. A bright line between dark lines, with a large gain, must saturate to 255. The inverse pattern must saturate to 0. A design that truncates the wide sum would instead wrap to a small or large wrong value.

Flat fields at 0 and 255 with the maximum gain must come back unchanged. A design that drops a sign bit in the edge term would shift them.

Edge terms of ±1 at half gain probe the rounding rule. Truncation toward zero, or floor without the half offset, yields an answer one step off.

Random back-to-back streams with valid gaps test the three-cycle alignment of valid and data. They also show that a stalled pipeline holds its output.

// File: rtl/vlap_sharpen.sv
module vlap_sharpen #(
  parameter int PIX_W  = 8,
  parameter int K_W    = 8,
  parameter int K_FRAC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_above,
  input  logic [PIX_W-1:0] pix_centre,
  input  logic [PIX_W-1:0] pix_below,
  input  logic [K_W-1:0]   gain,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  localparam int EW  = PIX_W + 3;
  localparam int PW  = EW + K_W + 1;
  localparam int RND = 1 << (K_FRAC - 1);

  // stage 1: edge term
  logic signed [EW-1:0] edge_c;
  logic signed [EW-1:0] s1_edge;
  logic [PIX_W-1:0]     s1_n;
  logic [K_W-1:0]       s1_k;
  logic                 s1_v;

  assign edge_c = $signed({{(EW-PIX_W-1){1'b0}}, pix_centre, 1'b0})
                - $signed({{(EW-PIX_W){1'b0}}, pix_above})
                - $signed({{(EW-PIX_W){1'b0}}, pix_below});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_edge <= '0;
      s1_n    <= '0;
      s1_k    <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_edge <= edge_c;
        s1_n    <= pix_centre;
        s1_k    <= gain;
      end
    end
  end

  // stage 2: gain and rounding
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_r;
  logic signed [PW-1:0] s2_scaled;
  logic [PIX_W-1:0]     s2_n;
  logic                 s2_v;

  assign prod   = PW'(s1_edge) * $signed({{(PW-K_W){1'b0}}, s1_k});
  assign prod_r = prod + $signed(PW'(RND));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v      <= 1'b0;
      s2_scaled <= '0;
      s2_n      <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_scaled <= prod_r >>> K_FRAC;
        s2_n      <= s1_n;
      end
    end
  end

  // stage 3: add back and saturate
  logic signed [PW:0] sum;
  logic [PIX_W-1:0]   sat;

  assign sum = $signed({{(PW+1-PIX_W){1'b0}}, s2_n}) + $signed({s2_scaled[PW-1], s2_scaled});
  assign sat = sum[PW] ? '0 : (|sum[PW-1:PIX_W] ? '1 : sum[PIX_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) out_pix <= sat;
    end
  end

  // checks
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_flat_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pix_above == pix_centre && pix_below == pix_centre) |=> (s1_edge == '0));

  a_r3_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_k == '0) |=> (s2_scaled == '0));

  a_r5_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && (($signed({1'b0, s2_n}) + s2_scaled) < 0)) |=> (out_pix == '0));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_v |=> $stable(out_pix));

endmodule

// File: tb/test_vlap_sharpen.sv
module test_vlap_sharpen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] pix_above = '0, pix_centre = '0, pix_below = '0, gain = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0;
  int errors = 0;
  bit mv [3];
  int md [3];
  int last_d = 0;

  always #5 clk = ~clk;

  vlap_sharpen i_vlap_sharpen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_above(pix_above), .pix_centre(pix_centre), .pix_below(pix_below),
    .gain(gain), .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int model(int a, int n, int b, int k);
    int e, s, r;
    e = 2*n - a - b;
    s = (e*k + 8) >>> 4;
    r = n + s;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, check at next negedge
  task automatic step(string req, bit v, int a, int n, int b, int k);
    in_valid = v; pix_above = 8'(a); pix_centre = 8'(n); pix_below = 8'(b); gain = 8'(k);
    @(posedge clk);
    mv[2] = mv[1]; md[2] = md[1];
    mv[1] = mv[0]; md[1] = md[0];
    mv[0] = v;     md[0] = v ? model(a, n, b, k) : 0;
    @(negedge clk);
    if (mv[2]) last_d = md[2];
    check({req, " valid"}, int'(out_valid), int'(mv[2]));
    check({req, " pixel"}, int'(out_pix), last_d);
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 3; i++) step(req, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 pixel in reset", int'(out_pix), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; md[i] = 0; end
    last_d = 0;
    step("R1", 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_flat;
    step("R2 all zero", 1'b1, 0, 0, 0, 255);
    step("R2 all full", 1'b1, 255, 255, 255, 255);
    step("R2 mid flat", 1'b1, 77, 77, 77, 200);
    drain("R2");
  endtask

  task automatic t_alternating;
    step("R5 bright line", 1'b1, 0, 255, 0, 255);
    step("R5 dark line", 1'b1, 255, 0, 255, 255);
    step("R4 unit gain", 1'b1, 40, 100, 40, 16);
    step("R4 negative edge", 1'b1, 90, 60, 50, 16);
    step("R5 just over", 1'b1, 0, 128, 0, 16);
    drain("R5");
  endtask

  task automatic t_rounding;
    step("R3 plus half", 1'b1, 49, 50, 50, 8);
    step("R3 minus half", 1'b1, 51, 50, 50, 8);
    step("R3 minus 3/4", 1'b1, 51, 50, 50, 12);
    step("R3 zero gain", 1'b1, 0, 200, 255, 0);
    step("R3 fraction", 1'b1, 10, 100, 30, 3);
    drain("R3");
  endtask

  task automatic t_stream;
    for (int i = 0; i < 60; i++)
      step("R6 stream", 1'b1, $urandom_range(255), $urandom_range(255),
           $urandom_range(255), $urandom_range(255));
    drain("R6");
  endtask

  task automatic t_stall;
    for (int i = 0; i < 60; i++)
      step("R7 gaps", ($urandom_range(2) == 0), $urandom_range(255),
           $urandom_range(255), $urandom_range(255), $urandom_range(255));
    drain("R7");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_flat();
    t_alternating();
    t_rounding();
    t_stream();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule